// File: doc/BRIEF.md
# Four-Operation ALU with Carry and Overflow Flags

This block is a small arithmetic logic unit for a datapath of parameterized width. Two operands and a two-bit operation code select between addition, subtraction, bitwise AND and bitwise OR. Addition and subtraction share one ripple chain of one-bit full adders. For subtraction, the second operand is inverted through XOR gates and a carry-in of one is injected at the least significant bit. All three candidate results (sum/difference, AND, OR) are formed every cycle, and a multiplexer passes the selected one to the result.

Besides the result, the unit reports the carry out of the top bit, an unsigned overflow flag whose sense depends on the operation, and a signed overflow flag. A thin register stage samples the result and flags on each rising clock edge, so a consumer sees the outcome one cycle after presenting the operands. A synchronous active-high reset clears that stage.

Top module: `alu4op_reg`

## Requirements
- R1: Operation code 2'b00 adds: the result is (a + b) mod 2^W and the carry flag is the carry out of bit W-1.
- R2: Operation code 2'b01 subtracts: the result is (a - b) mod 2^W, computed as a + ~b + 1, and the carry flag is the carry out of that sum (1 when a >= b unsigned).
- R3: Operation code 2'b10 gives a AND b and code 2'b11 gives a OR b, bit by bit.
- R4: The unsigned overflow flag equals the carry flag when adding and the inverse of the carry flag when subtracting.
- R5: The signed overflow flag is set exactly when the two's-complement result of the add or subtract does not fit in W bits. This is the case when the carry into bit W-1 differs from the carry out of it. For W=4, 0111+0001, 0100+0100, 1000+1111 and 1011+1011 all set it.
- R6: For the AND and OR codes, the carry, unsigned overflow and signed overflow outputs are all 0.
- R7: Result and flags are registered: operands applied before a rising edge appear on the outputs after that edge and stay until the next edge.
- R8: While rst is high at a rising edge, every output is cleared to 0 after that edge, whatever the operands and operation code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | W | First operand |
| b_in | input | W | Second operand |
| op_in | input | 2 | Operation code: 00 add, 01 subtract, 10 AND, 11 OR |
| res_q | output | W | Registered result |
| carry_q | output | 1 | Registered carry out of the top bit (0 for AND/OR) |
| uovf_q | output | 1 | Registered unsigned overflow |
| sovf_q | output | 1 | Registered signed overflow |

## Verification
The bench goes after the polarity of unsigned overflow. A design that applied the add rule to subtraction would flag 0101-0101 and miss 0011-0101. It also goes after signed overflow from both directions: positive plus positive wrapping negative, and negative plus negative wrapping positive. A design that used only the top carry, or only the sign of the result, would miss one of these families. Equal-operand subtraction and the most negative value minus one check that the carry-in of one reaches bit zero and that the operand inversion is complete. Logic operations with all-ones operands catch flags that leak from the idle adder.

// File: rtl/alu4op_pkg.sv
package alu4op_pkg;
    typedef enum logic [1:0] {
        OP_ADD = 2'b00,
        OP_SUB = 2'b01,
        OP_AND = 2'b10,
        OP_OR  = 2'b11
    } alu_op_e;
endpackage

// File: rtl/alu_fa_cell.sv
module alu_fa_cell (
    input  logic x,
    input  logic y,
    input  logic cin,
    output logic s,
    output logic cout
);
    always_comb begin
        s    = x ^ y ^ cin;
        cout = (x & y) | (x & cin) | (y & cin);
    end
endmodule

// File: rtl/alu_addsub_chain.sv
module alu_addsub_chain #(
    parameter int W = 4
) (
    input  logic         sub,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] sum,
    output logic         c_top_out,
    output logic         c_top_in
);
    logic [W:0]   carry;
    logic [W-1:0] b_eff;

    assign b_eff    = b ^ {W{sub}};
    assign carry[0] = sub;

    for (genvar i = 0; i < W; i++) begin : g_bit
        alu_fa_cell u_fa (
            .x   (a[i]),
            .y   (b_eff[i]),
            .cin (carry[i]),
            .s   (sum[i]),
            .cout(carry[i+1])
        );
    end

    assign c_top_out = carry[W];
    assign c_top_in  = carry[W-1];
endmodule

// File: rtl/alu_result_sel.sv
module alu_result_sel
    import alu4op_pkg::*;
#(
    parameter int W = 4
) (
    input  alu_op_e      op,
    input  logic [W-1:0] arith,
    input  logic [W-1:0] and_v,
    input  logic [W-1:0] or_v,
    input  logic         c_top_out,
    input  logic         c_top_in,
    output logic [W-1:0] res,
    output logic         carry,
    output logic         uovf,
    output logic         sovf
);
    always_comb begin
        res   = '0;
        carry = 1'b0;
        uovf  = 1'b0;
        sovf  = 1'b0;
        unique case (op)
            OP_ADD: begin
                res   = arith;
                carry = c_top_out;
                uovf  = c_top_out;
                sovf  = c_top_in ^ c_top_out;
            end
            OP_SUB: begin
                res   = arith;
                carry = c_top_out;
                uovf  = ~c_top_out;
                sovf  = c_top_in ^ c_top_out;
            end
            OP_AND: res = and_v;
            OP_OR:  res = or_v;
        endcase
    end
endmodule

// File: rtl/alu4op_reg.sv
module alu4op_reg
    import alu4op_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    input  logic [1:0]   op_in,
    output logic [W-1:0] res_q,
    output logic         carry_q,
    output logic         uovf_q,
    output logic         sovf_q
);
    localparam int MSB = W - 1;

    alu_op_e      op;
    logic [W-1:0] arith, and_v, or_v, res_d;
    logic         c_out, c_in_top, carry_d, uovf_d, sovf_d;

    assign op    = alu_op_e'(op_in);
    assign and_v = a_in & b_in;
    assign or_v  = a_in | b_in;

    alu_addsub_chain #(.W(W)) u_chain (
        .sub      (op == OP_SUB),
        .a        (a_in),
        .b        (b_in),
        .sum      (arith),
        .c_top_out(c_out),
        .c_top_in (c_in_top)
    );

    alu_result_sel #(.W(W)) u_sel (
        .op       (op),
        .arith    (arith),
        .and_v    (and_v),
        .or_v     (or_v),
        .c_top_out(c_out),
        .c_top_in (c_in_top),
        .res      (res_d),
        .carry    (carry_d),
        .uovf     (uovf_d),
        .sovf     (sovf_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q   <= '0;
            carry_q <= 1'b0;
            uovf_q  <= 1'b0;
            sovf_q  <= 1'b0;
        end else begin
            res_q   <= res_d;
            carry_q <= carry_d;
            uovf_q  <= uovf_d;
            sovf_q  <= sovf_d;
        end
    end

    // R4
    uovf_add_chk: assert property (@(posedge clk) disable iff (rst)
        (op_in == 2'b00) |=> (uovf_q == carry_q));
    // R4
    uovf_sub_chk: assert property (@(posedge clk) disable iff (rst)
        (op_in == 2'b01) |=> (uovf_q == !carry_q));
    // R6
    logic_flags_chk: assert property (@(posedge clk) disable iff (rst)
        (op_in[1]) |=> (!carry_q && !uovf_q && !sovf_q));
    // R3
    and_res_chk: assert property (@(posedge clk) disable iff (rst)
        (op_in == 2'b10) |=> (res_q == ($past(a_in) & $past(b_in))));
    // R5
    sovf_add_chk: assert property (@(posedge clk) disable iff (rst)
        (op_in == 2'b00) |=>
        (sovf_q == (($past(a_in[MSB]) == $past(b_in[MSB])) && (res_q[MSB] != $past(a_in[MSB])))));
    // R5
    sovf_sub_chk: assert property (@(posedge clk) disable iff (rst)
        (op_in == 2'b01) |=>
        (sovf_q == (($past(a_in[MSB]) != $past(b_in[MSB])) && (res_q[MSB] != $past(a_in[MSB])))));
    // R8
    rst_clear_chk: assert property (@(posedge clk)
        rst |=> (res_q == '0 && !carry_q && !uovf_q && !sovf_q));
endmodule

// File: tb/tb_alu4op_reg.sv
module tb_alu4op_reg;
    localparam int W = 4;
    localparam time CLK_PERIOD = 10ns;
    localparam int NVEC = 12;

    // entry: {op[1:0], a[3:0], b[3:0], res[3:0], carry, uovf, sovf}
    localparam logic [16:0] VEC [NVEC] = '{
        {2'b00, 4'b0111, 4'b0001, 4'b1000, 3'b001},
        {2'b00, 4'b0100, 4'b0100, 4'b1000, 3'b001},
        {2'b00, 4'b1000, 4'b1111, 4'b0111, 3'b111},
        {2'b00, 4'b1011, 4'b1011, 4'b0110, 3'b111},
        {2'b00, 4'b1000, 4'b1000, 4'b0000, 3'b111},
        {2'b00, 4'b1111, 4'b0001, 4'b0000, 3'b110},
        {2'b01, 4'b0101, 4'b0101, 4'b0000, 3'b100},
        {2'b01, 4'b0011, 4'b0101, 4'b1110, 3'b010},
        {2'b01, 4'b1000, 4'b0001, 4'b0111, 3'b101},
        {2'b01, 4'b0111, 4'b1111, 4'b1000, 3'b011},
        {2'b10, 4'b1100, 4'b1010, 4'b1000, 3'b000},
        {2'b11, 4'b1100, 4'b1010, 4'b1110, 3'b000}
    };

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] a_in = '0, b_in = '0;
    logic [1:0]   op_in = 2'b00;
    logic [W-1:0] res_q;
    logic         carry_q, uovf_q, sovf_q;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    alu4op_reg #(.W(W)) dut (
        .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in), .op_in(op_in),
        .res_q(res_q), .carry_q(carry_q), .uovf_q(uovf_q), .sovf_q(sovf_q)
    );

    function automatic logic [W+2:0] ref_model(logic [1:0] op, logic [W-1:0] a, logic [W-1:0] b);
        logic [W:0]   full;
        logic [W-1:0] r;
        logic         c, u, s;
        c = 1'b0; u = 1'b0; s = 1'b0;
        case (op)
            2'b00: begin
                full = {1'b0, a} + {1'b0, b};
                r = full[W-1:0]; c = full[W]; u = c;
                s = (a[W-1] == b[W-1]) && (r[W-1] != a[W-1]);
            end
            2'b01: begin
                full = {1'b0, a} + {1'b0, ~b} + 1;
                r = full[W-1:0]; c = full[W]; u = (a < b);
                s = (a[W-1] != b[W-1]) && (r[W-1] != a[W-1]);
            end
            2'b10: r = a & b;
            default: r = a | b;
        endcase
        return {r, c, u, s};
    endfunction

    task automatic check(string req, logic [W+2:0] exp);
        logic [W+2:0] act;
        act = {res_q, carry_q, uovf_q, sovf_q};
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s op=%b a=%b b=%b actual={r,c,u,s}=%b expected=%b",
                     req, op_in, a_in, b_in, act, exp);
        end
    endtask

    task automatic apply(logic [1:0] op, logic [W-1:0] a, logic [W-1:0] b);
        @(negedge clk);
        op_in = op; a_in = a; b_in = b;
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R8: reset state with live operands
        op_in = 2'b00; a_in = 4'b1111; b_in = 4'b0001;
        repeat (2) @(negedge clk);
        check("R8 reset clears", '0);
        @(negedge clk);
        rst = 1'b0;

        // table of corner vectors: R1 R2 R3 R4 R5 R6
        for (int i = 0; i < NVEC; i++) begin
            apply(VEC[i][16:15], VEC[i][14:11], VEC[i][10:7]);
            check("R1/R2/R3/R4/R5/R6 table", VEC[i][6:0]);
        end

        // R7: output holds until next edge, updates after it
        @(negedge clk);
        op_in = 2'b11; a_in = 4'b0101; b_in = 4'b0010;
        #1;
        check("R7 hold before edge", ref_model(2'b11, 4'b1100, 4'b1010));
        @(negedge clk);
        check("R7 update after edge", ref_model(2'b11, 4'b0101, 4'b0010));

        // R6: logic ops with all-ones operands leave flags low
        apply(2'b10, 4'b1111, 4'b1111);
        check("R6 AND flags low", {4'b1111, 3'b000});
        apply(2'b11, 4'b1111, 4'b1111);
        check("R6 OR flags low", {4'b1111, 3'b000});

        // exhaustive sweep: R1 R2 R3 R4 R5 R6
        for (int o = 0; o < 4; o++) begin
            for (int x = 0; x < 16; x++) begin
                for (int y = 0; y < 16; y++) begin
                    apply(o[1:0], x[W-1:0], y[W-1:0]);
                    check("R1/R2/R3/R4/R5/R6 sweep", ref_model(o[1:0], x[W-1:0], y[W-1:0]));
                end
            end
        end

        // R8: reset mid-run dominates a producing operation
        @(negedge clk);
        op_in = 2'b00; a_in = 4'b1000; b_in = 4'b1000; rst = 1'b1;
        @(negedge clk);
        check("R8 reset dominates", '0);
        rst = 1'b0;
        @(negedge clk);
        check("R8 resume after reset", {4'b0000, 3'b111});

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule